// File: doc/BRIEF.md
# Video Stream Capture Gate

The block sits between a parallel RGB pixel source and a slice memory. A host-controlled enable level arms it. Once armed, it discards everything until a vsync marker signals the start of an image. From then on, every valid pixel is written into the memory at consecutive addresses. The memory is treated as a circular buffer that holds `BUF_SLICES` slices.

A slice holds `COLS * PIX_PER_COL` pixels, which is 512 by default. After `READY_SLICES` complete slices have been written (two by default), the block raises a ready flag for the downstream readers. The flag stays up for as long as the enable holds.

Dropping the enable stops writing, clears the flag and the counters, and makes the block wait for a fresh vsync before capturing again. A vsync that arrives during capture realigns the write address to zero, so every image starts at slice zero.

Top module: `vcg_top`

## Requirements
- R1: While `capture_en_i` is low, `ram_we_o` stays low, whatever arrives on the pixel inputs.
- R2: After the enable rises, no pixel is written until a cycle with `vsync_i` high has been seen with the enable high. Pixels that arrive before that are dropped.
- R3: A pixel is accepted in a cycle where capture is active, `capture_en_i` and `pix_valid_i` are high, and `vsync_i` is low. In the following cycle, `ram_we_o` is 1 and `ram_data_o` carries that pixel. Accepted pixels take consecutive addresses, starting at 0 after each vsync.
- R4: `stream_ready_o` is low until the write of pixel number `READY_SLICES*COLS*PIX_PER_COL` since arming. It rises in the same cycle that this write appears on the RAM port.
- R5: Once high, `stream_ready_o` stays high while `capture_en_i` stays high. This holds across address wrap and across vsync.
- R6: After address `BUF_SLICES*COLS*PIX_PER_COL-1`, the next write goes to address 0.
- R7: A vsync during capture sends the next accepted pixel to address 0. A pixel presented in the same cycle as vsync is not written.
- R8: If `capture_en_i` is sampled low, `stream_ready_o` is low from the next cycle, and the slice count restarts from zero. After re-enabling, the block again waits for vsync.
- R9: After reset, `ram_we_o` and `stream_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_en_i | input | 1 | Host enable level |
| pix_valid_i | input | 1 | Pixel data valid |
| vsync_i | input | 1 | Start-of-image marker, one cycle |
| pix_data_i | input | DATA_W | RGB pixel |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_data_o | output | DATA_W | RAM write data |
| stream_ready_o | output | 1 | Enough slices stored |

## Verification
The assertions assume the following about the inputs:
- all inputs are synchronous to `clk_i`;
- vsync is a marker that carries no pixel;
- the enable is a level that the host changes only occasionally.

The stimulus keeps within these assumptions. It drives every input half a cycle away from the sampling edge, and it raises vsync for single cycles only. It mixes valid gaps into the stream, toggles the enable between whole phases of the test, and places one pixel on a vsync cycle so that the drop rule is exercised.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/vcg_frame_ctrl.sv
module vcg_frame_ctrl
  import vcg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_en_i,
  input  logic       vsync_i,
  input  logic       pix_valid_i,
  output cap_state_e state_o,
  output logic       accept_o,
  output logic       realign_o
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!capture_en_i)          state_d = ST_IDLE;
    else if (vsync_i)           state_d = ST_CAPTURE;
    else if (state_q == ST_IDLE) state_d = ST_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign accept_o  = (state_q == ST_CAPTURE) && capture_en_i && pix_valid_i && !vsync_i;
  assign realign_o = capture_en_i && vsync_i;

  // capture only entered through a vsync seen with enable high
  assert_capture_via_vsync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_CAPTURE) && !(capture_en_i && vsync_i) |=> state_q != ST_CAPTURE);
endmodule

// File: rtl/vcg_addr_gen.sv
module vcg_addr_gen #(
  parameter int PIX_PER_SLICE = 512,
  parameter int BUF_SLICES    = 4,
  parameter int READY_SLICES  = 2,
  localparam int DEPTH  = PIX_PER_SLICE * BUF_SLICES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PIX_W  = $clog2(PIX_PER_SLICE),
  localparam int SLC_W  = $clog2(READY_SLICES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_en_i,
  input  logic              accept_i,
  input  logic              realign_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              ready_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_inc;
  logic [PIX_W-1:0]  pix_q;
  logic [SLC_W-1:0]  slc_q;
  logic              slice_last;

  generate
    if (DEPTH == (1 << ADDR_W)) begin : g_pow2_wrap
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_cmp_wrap
      assign ptr_inc = (ptr_q == ADDR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  assign slice_last = (pix_q == PIX_W'(PIX_PER_SLICE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      pix_q <= '0;
      slc_q <= '0;
    end else if (!capture_en_i) begin
      ptr_q <= '0;
      pix_q <= '0;
      slc_q <= '0;
    end else if (realign_i) begin
      ptr_q <= '0;
      pix_q <= '0;
    end else if (accept_i) begin
      ptr_q <= ptr_inc;
      pix_q <= slice_last ? '0 : pix_q + 1'b1;
      if (slice_last && (slc_q != SLC_W'(READY_SLICES))) slc_q <= slc_q + 1'b1;
    end
  end

  assign wr_ptr_o = ptr_q;
  assign ready_o  = (slc_q == SLC_W'(READY_SLICES));

  assert_ptr_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && capture_en_i && !realign_i && (ptr_q == ADDR_W'(DEPTH - 1)) |=> ptr_q == '0);
  assert_ready_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && capture_en_i |=> ready_o);
endmodule

// File: rtl/vcg_wr_port.sv
module vcg_wr_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= accept_i;
      if (accept_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/vcg_top.sv
module vcg_top
  import vcg_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int COLS         = 8,
  parameter int PIX_PER_COL  = 64,
  parameter int BUF_SLICES   = 4,
  parameter int READY_SLICES = 2,
  localparam int PIX_PER_SLICE = COLS * PIX_PER_COL,
  localparam int ADDR_W        = $clog2(PIX_PER_SLICE * BUF_SLICES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_en_i,
  input  logic              pix_valid_i,
  input  logic              vsync_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              stream_ready_o
);
  cap_state_e        state;
  logic              accept, realign;
  logic [ADDR_W-1:0] wr_ptr;

  vcg_frame_ctrl i_frame_ctrl (
    .clk_i, .rst_ni, .capture_en_i, .vsync_i, .pix_valid_i,
    .state_o(state), .accept_o(accept), .realign_o(realign)
  );

  vcg_addr_gen #(
    .PIX_PER_SLICE(PIX_PER_SLICE), .BUF_SLICES(BUF_SLICES), .READY_SLICES(READY_SLICES)
  ) i_addr_gen (
    .clk_i, .rst_ni, .capture_en_i, .accept_i(accept), .realign_i(realign),
    .wr_ptr_o(wr_ptr), .ready_o(stream_ready_o)
  );

  vcg_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr_port (
    .clk_i, .rst_ni, .accept_i(accept), .addr_i(wr_ptr), .data_i(pix_data_i),
    .we_o(ram_we_o), .addr_o(ram_addr_o), .data_o(ram_data_o)
  );

  assert_no_write_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_en_i |=> !ram_we_o);
  assert_no_write_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_CAPTURE) |=> !ram_we_o);
  assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_en_i |=> !stream_ready_o);
  assert_vsync_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> !ram_we_o);
endmodule

// File: tb/test_vcg_top.sv
module test_vcg_top;
  localparam int DATA_W = 24;
  localparam int PPS    = 512;
  localparam int BUFS   = 4;
  localparam int RDY    = 2;
  localparam int DEPTH  = PPS * BUFS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, valid = 1'b0, vsync = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic we, ready;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  int checks = 0, fails = 0, writes = 0;
  logic [ADDR_W+DATA_W-1:0] exp_q[$];

  int m_state = 0, m_ptr = 0, m_pix = 0, m_slc = 0;

  always #10 clk = ~clk;

  vcg_top i_vcg_top (
    .clk_i(clk), .rst_ni(rst_n), .capture_en_i(en), .pix_valid_i(valid),
    .vsync_i(vsync), .pix_data_i(data), .ram_we_o(we), .ram_addr_o(addr),
    .ram_data_o(wdata), .stream_ready_o(ready)
  );

  // monitor: pop and compare every write
  always @(posedge clk) begin
    #5;
    if (rst_n && we) begin
      writes++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1/R2/R7 unexpected write addr=%0d data=%h expected none", addr, wdata);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        if ({addr, wdata} !== e) begin
          fails++;
          $display("FAIL R3/R6/R7 write addr=%0d data=%h expected addr=%0d data=%h",
                   addr, wdata, e[ADDR_W+DATA_W-1:DATA_W], e[DATA_W-1:0]);
        end
      end
    end
  end

  task automatic cyc(input logic e_i, input logic v_i, input logic s_i, input logic [DATA_W-1:0] d_i);
    @(negedge clk);
    en = e_i; valid = v_i; vsync = s_i; data = d_i;
    if (e_i && v_i && !s_i && m_state == 2) begin
      exp_q.push_back({ADDR_W'(m_ptr), d_i});
      m_ptr = (m_ptr + 1) % DEPTH;
      if (m_pix == PPS - 1) begin
        m_pix = 0;
        if (m_slc < RDY) m_slc++;
      end else m_pix++;
    end
    if (!e_i) begin
      m_state = 0; m_ptr = 0; m_pix = 0; m_slc = 0;
    end else if (s_i) begin
      m_state = 2; m_ptr = 0; m_pix = 0;
    end else if (m_state == 0) m_state = 1;
  endtask

  task automatic chk_ready(input string tag);
    @(posedge clk); #5;
    checks++;
    if (ready !== (m_slc == RDY)) begin
      fails++;
      $display("FAIL %s stream_ready=%b expected %b", tag, ready, m_slc == RDY);
    end
  endtask

  task automatic chk_writes(input int exp_n, input string tag);
    @(posedge clk); #5;
    checks++;
    if (writes != exp_n) begin
      fails++;
      $display("FAIL %s writes=%0d expected %0d", tag, writes, exp_n);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (we !== 1'b0 || ready !== 1'b0) begin
      fails++;
      $display("FAIL R9 we=%b ready=%b expected 0 0", we, ready);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1: disabled, stream with vsync ignored
    cyc(0, 0, 1, '0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, DATA_W'(i));
    chk_writes(0, "R1 disabled");

    // R2: enabled, pixels before vsync dropped
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, DATA_W'(100 + i));
    chk_writes(0, "R2 pre-vsync");
    chk_ready("R4 low before start");

    // R3/R4: vsync then two slices with gaps
    cyc(1, 0, 1, '0);
    for (int i = 0; i < RDY * PPS - 1; i++) begin
      cyc(1, 1, 0, DATA_W'(24'h10000 + i));
      if (i % 7 == 3) cyc(1, 0, 0, 24'hdead);
    end
    chk_ready("R4 one pixel short");
    cyc(1, 1, 0, 24'h0abcde);
    chk_ready("R4 rise on threshold write");

    // R6/R5: run past the end of the buffer
    for (int i = 0; i < DEPTH - RDY * PPS + 10; i++) cyc(1, 1, 0, DATA_W'(24'h200000 + i));
    chk_ready("R5 held across wrap R6");

    // R7: vsync with a pixel on it, realign to zero
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, DATA_W'(24'h300000 + i));
    cyc(1, 1, 1, 24'hbadbad);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, DATA_W'(24'h400000 + i));
    chk_ready("R5 held across vsync R7");

    // R8: drop enable
    cyc(0, 1, 0, 24'h555555);
    chk_ready("R8 cleared after disable");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, DATA_W'(i));
    begin
      int w0;
      w0 = writes;
      for (int i = 0; i < 8; i++) cyc(1, 1, 0, DATA_W'(24'h600000 + i));
      chk_writes(w0, "R8 rearm waits vsync");
      cyc(1, 0, 1, '0);
      for (int i = 0; i < PPS; i++) cyc(1, 1, 0, DATA_W'(24'h700000 + i));
      chk_ready("R8 slice count restarted");
    end
    for (int i = 0; i < PPS; i++) cyc(1, 1, 0, DATA_W'(24'h800000 + i));
    chk_ready("R4 second arming reaches threshold");
    cyc(1, 0, 0, '0);
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 pending writes=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule